// File: doc/BRIEF.md
# Line-Cycle Skip Controller for Light-Load Power Factor Correction

This block decides, one AC line cycle at a time, whether a power factor correction stage switches or stays idle while the load is light. With no output current sensor available, the voltage-loop output word is used as a load estimate. Once that estimate has stayed low for several line cycles, the controller enters a burst pattern: it blanks a number of whole line cycles, switches for one full cycle, and repeats. The lighter the load, the more cycles are blanked. Every on/off change is aligned to a line zero-crossing strobe, so each blanked interval covers complete AC cycles.

While switching is blanked, the current-loop and voltage-loop integrators are held frozen. This prevents an oversized first PWM pulse when switching resumes. The freeze overlaps the PWM-enable transitions by one clock on each side. A low-output-voltage comparator flag forces an immediate exit from burst operation, without waiting for a zero crossing. After that exit, re-entry is blocked for a programmable number of line cycles. The blank count comes from a small set of programmable load breakpoints.

Top module: `burst_skip_ctrl`

## Requirements
- R1: Outside an emergency exit, `pwm_en_o` changes only as a consequence of a zero-crossing strobe. A load change in the middle of a line cycle leaves `pwm_en_o` unchanged.
- R2: Burst mode (`burst_o`=1) is entered at the fourth consecutive zero crossing at which `burst_en_i`=1, `load_i` < `enter_th_i` and no lockout is pending. Any zero crossing that fails this condition restarts the count.
- R3: In burst mode, a zero crossing with `load_i` > `exit_th_i` or `burst_en_i`=0 returns the block to normal switching (`burst_o`=0, `pwm_en_o`=1, `skip_cnt_o`=0). A load between the two thresholds keeps burst mode.
- R4: The blank count is the number of entries of `bp_i` (three 12-bit fields) that `load_i` is strictly below, giving 0 to 3. It is sampled at the zero crossing that starts a pattern and shown on `skip_cnt_o`. A count of 0 keeps switching.
- R5: After N blanked line cycles (`pwm_en_o`=0), the block switches for exactly one line cycle and then samples a new count.
- R6: `uv_i`=1 during burst mode forces `burst_o`=0 and `pwm_en_o`=1 on the next clock edge, with no zero crossing required.
- R7: After an emergency exit, the next `lockout_i` zero crossings cannot count toward entry.
- R8: `freeze_o` rises one clock before `pwm_en_o` falls, and falls one clock after `pwm_en_o` rises.
- R9: After reset, `pwm_en_o`=1, `freeze_o`=0, `burst_o`=0 and `skip_cnt_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| zc_i | input | 1 | One-clock strobe marking a line zero crossing |
| load_i | input | 12 | Voltage-loop output used as the load estimate |
| uv_i | input | 1 | Output voltage below its minimum |
| burst_en_i | input | 1 | Allows burst operation |
| enter_th_i | input | 12 | Threshold for entering burst mode |
| exit_th_i | input | 12 | Threshold for leaving burst mode (set above enter_th_i) |
| bp_i | input | 36 | Three load breakpoints for the blank count |
| lockout_i | input | 8 | Zero crossings of lockout after an emergency exit |
| pwm_en_o | output | 1 | Enables the PWM modulator |
| freeze_o | output | 1 | Holds the loop integrators |
| burst_o | output | 1 | Burst mode active |
| skip_cnt_o | output | 2 | Blank count of the current pattern |

## Verification
The bench sweeps the load down through every breakpoint band. It expects 0, 1, 2 and then 3 blanked cycles, each followed by exactly one switching cycle; a design with an off-by-one in its remaining-cycle counter would blank one cycle too many or too few. It places one entry streak so that it is broken by a load just above the entry threshold, and it parks a load between the thresholds. A design lacking hysteresis or a count reset would enter early or leave early. An undervoltage is raised in the middle of a blanked cycle: a design that waits for a zero crossing would leave the PWM off. The bench then counts the lockout crossings and probes each clock around an off and an on edge, which catches a freeze that does not overlap PWM enable.

// File: rtl/burst_skip_pkg.sv
package burst_skip_pkg;
  typedef enum logic [1:0] {
    ST_NORMAL = 2'd0,
    ST_ON     = 2'd1,
    ST_OFF    = 2'd2
  } burst_st_e;
endpackage

// File: rtl/burst_skip_map.sv
module burst_skip_map #(
  parameter int LOAD_W = 12,
  parameter int NUM_BP = 3,
  localparam int SKIP_W = $clog2(NUM_BP + 1)
) (
  input  logic [LOAD_W-1:0]        load_i,
  input  logic [NUM_BP*LOAD_W-1:0] bp_i,
  output logic [SKIP_W-1:0]        skip_o
);
  logic [NUM_BP-1:0] below;

  for (genvar k = 0; k < NUM_BP; k++) begin : g_cmp
    assign below[k] = load_i < bp_i[k*LOAD_W +: LOAD_W];
  end

  // order of breakpoints is irrelevant: count how many lie above the load
  always_comb begin
    skip_o = '0;
    for (int k = 0; k < NUM_BP; k++) skip_o = skip_o + SKIP_W'(below[k]);
  end
endmodule

// File: rtl/burst_entry_qual.sv
module burst_entry_qual #(
  parameter int ENTRY_CNT = 4,
  parameter int LOCK_W    = 8,
  localparam int CNT_W    = $clog2(ENTRY_CNT + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              zc_i,
  input  logic              qual_i,
  input  logic              in_burst_i,
  input  logic              uv_i,
  input  logic [LOCK_W-1:0] lockout_i,
  output logic              enter_o
);
  logic [CNT_W-1:0]  cnt_q;
  logic [LOCK_W-1:0] lock_q;
  logic              locked;

  assign locked  = lock_q != '0;
  assign enter_o = zc_i && qual_i && !locked && !in_burst_i && !uv_i &&
                   (cnt_q == CNT_W'(ENTRY_CNT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      lock_q <= '0;
    end else begin
      if (uv_i && in_burst_i)     lock_q <= lockout_i;
      else if (zc_i && locked)    lock_q <= lock_q - 1'b1;

      if (uv_i || in_burst_i)                cnt_q <= '0;
      else if (zc_i) begin
        if (locked || !qual_i || enter_o)    cnt_q <= '0;
        else                                 cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/burst_seq.sv
module burst_seq
  import burst_skip_pkg::*;
#(
  parameter int SKIP_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              zc_i,
  input  logic              enter_i,
  input  logic              exit_i,
  input  logic              uv_i,
  input  logic [SKIP_W-1:0] skip_i,
  output logic              in_burst_o,
  output logic              pwm_en_o,
  output logic              freeze_o,
  output logic [SKIP_W-1:0] skip_cnt_o
);
  burst_st_e         st_q;
  logic [SKIP_W-1:0] rem_q, skip_q;
  logic              gate_q, gate_d1_q;

  assign in_burst_o = st_q != ST_NORMAL;
  assign skip_cnt_o = skip_q;
  // off: freeze leads pwm drop by one clock; on: freeze trails pwm rise by one
  assign pwm_en_o   = gate_q | gate_d1_q;
  assign freeze_o   = !(gate_q & gate_d1_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_NORMAL;
      rem_q     <= '0;
      skip_q    <= '0;
      gate_q    <= 1'b1;
      gate_d1_q <= 1'b1;
    end else begin
      gate_d1_q <= gate_q;
      if (in_burst_o && uv_i) begin
        st_q   <= ST_NORMAL;
        gate_q <= 1'b1;
        skip_q <= '0;
        rem_q  <= '0;
      end else if (zc_i) begin
        unique case (st_q)
          ST_NORMAL, ST_ON: begin
            if (st_q == ST_ON && exit_i) begin
              st_q   <= ST_NORMAL;
              gate_q <= 1'b1;
              skip_q <= '0;
            end else if (st_q == ST_ON || enter_i) begin
              skip_q <= skip_i;
              if (skip_i != '0) begin
                st_q   <= ST_OFF;
                gate_q <= 1'b0;
                rem_q  <= skip_i - 1'b1;
              end else begin
                st_q   <= ST_ON;
                gate_q <= 1'b1;
              end
            end
          end
          ST_OFF: begin
            if (exit_i) begin
              st_q   <= ST_NORMAL;
              gate_q <= 1'b1;
              skip_q <= '0;
              rem_q  <= '0;
            end else if (rem_q != '0) begin
              rem_q <= rem_q - 1'b1;
            end else begin
              st_q   <= ST_ON;
              gate_q <= 1'b1;
            end
          end
          default: st_q <= ST_NORMAL;
        endcase
      end
    end
  end
endmodule

// File: rtl/burst_skip_ctrl.sv
module burst_skip_ctrl #(
  parameter int LOAD_W    = 12,
  parameter int NUM_BP    = 3,
  parameter int ENTRY_CNT = 4,
  parameter int LOCK_W    = 8,
  localparam int SKIP_W   = $clog2(NUM_BP + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     zc_i,
  input  logic [LOAD_W-1:0]        load_i,
  input  logic                     uv_i,
  input  logic                     burst_en_i,
  input  logic [LOAD_W-1:0]        enter_th_i,
  input  logic [LOAD_W-1:0]        exit_th_i,
  input  logic [NUM_BP*LOAD_W-1:0] bp_i,
  input  logic [LOCK_W-1:0]        lockout_i,
  output logic                     pwm_en_o,
  output logic                     freeze_o,
  output logic                     burst_o,
  output logic [SKIP_W-1:0]        skip_cnt_o
);
  logic [SKIP_W-1:0] skip_n;
  logic              qual, exit_req, enter, in_burst;

  assign qual     = burst_en_i && (load_i < enter_th_i);
  assign exit_req = !burst_en_i || (load_i > exit_th_i);
  assign burst_o  = in_burst;

  burst_skip_map #(.LOAD_W(LOAD_W), .NUM_BP(NUM_BP)) u_map (
    .load_i (load_i),
    .bp_i   (bp_i),
    .skip_o (skip_n)
  );

  burst_entry_qual #(.ENTRY_CNT(ENTRY_CNT), .LOCK_W(LOCK_W)) u_qual (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .zc_i       (zc_i),
    .qual_i     (qual),
    .in_burst_i (in_burst),
    .uv_i       (uv_i),
    .lockout_i  (lockout_i),
    .enter_o    (enter)
  );

  burst_seq #(.SKIP_W(SKIP_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .zc_i       (zc_i),
    .enter_i    (enter),
    .exit_i     (exit_req),
    .uv_i       (uv_i),
    .skip_i     (skip_n),
    .in_burst_o (in_burst),
    .pwm_en_o   (pwm_en_o),
    .freeze_o   (freeze_o),
    .skip_cnt_o (skip_cnt_o)
  );
endmodule

// File: rtl/burst_skip_chk.sv
module burst_skip_chk #(
  parameter int SKIP_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              zc_i,
  input logic              uv_i,
  input logic              burst_en_i,
  input logic              pwm_en_o,
  input logic              freeze_o,
  input logic              burst_o,
  input logic [SKIP_W-1:0] skip_cnt_o
);
  AST_OFF_AT_ZC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pwm_en_o) |-> $past(zc_i, 2)); // R1
  AST_NO_ENTRY_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!burst_en_i && !burst_o) |=> !burst_o); // R2
  AST_NORMAL_SWITCHES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !burst_o |-> (pwm_en_o && skip_cnt_o == '0)); // R3
  AST_UV_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uv_i |=> (pwm_en_o && !burst_o)); // R6
  AST_FREEZE_LEAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pwm_en_o) |-> $past(freeze_o)); // R8
  AST_FREEZE_LAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwm_en_o) |-> freeze_o); // R8
  AST_FREEZE_OFF_WHEN_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(pwm_en_o) && pwm_en_o && !$rose(freeze_o) |-> !freeze_o); // R8
endmodule

bind burst_skip_ctrl burst_skip_chk #(.SKIP_W(SKIP_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .zc_i       (zc_i),
  .uv_i       (uv_i),
  .burst_en_i (burst_en_i),
  .pwm_en_o   (pwm_en_o),
  .freeze_o   (freeze_o),
  .burst_o    (burst_o),
  .skip_cnt_o (skip_cnt_o)
);

// File: tb/burst_skip_ctrl_test.sv
module burst_skip_ctrl_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        zc_i = 1'b0;
  logic [11:0] load_i = 12'd1000;
  logic        uv_i = 1'b0;
  logic        burst_en_i = 1'b1;
  logic [11:0] enter_th_i = 12'd400;
  logic [11:0] exit_th_i = 12'd600;
  logic [35:0] bp_i = {12'd100, 12'd200, 12'd300};
  logic [7:0]  lockout_i = 8'd3;
  logic        pwm_en_o, freeze_o, burst_o;
  logic [1:0]  skip_cnt_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  burst_skip_ctrl uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .zc_i(zc_i), .load_i(load_i), .uv_i(uv_i),
    .burst_en_i(burst_en_i), .enter_th_i(enter_th_i), .exit_th_i(exit_th_i),
    .bp_i(bp_i), .lockout_i(lockout_i), .pwm_en_o(pwm_en_o), .freeze_o(freeze_o),
    .burst_o(burst_o), .skip_cnt_o(skip_cnt_o)
  );

  // {load[11:0], en, exp_burst, exp_pwm, exp_skip[1:0]}
  localparam int NV = 22;
  localparam logic [16:0] VEC [0:NV-1] = '{
    {12'd350, 1'b1, 1'b0, 1'b1, 2'd0},  // R2 streak 1
    {12'd350, 1'b1, 1'b0, 1'b1, 2'd0},
    {12'd350, 1'b1, 1'b0, 1'b1, 2'd0},
    {12'd350, 1'b1, 1'b1, 1'b1, 2'd0},  // R2 enter, R4 zero blanks
    {12'd250, 1'b1, 1'b1, 1'b0, 2'd1},  // R4 one
    {12'd250, 1'b1, 1'b1, 1'b1, 2'd1},  // R5 on cycle
    {12'd150, 1'b1, 1'b1, 1'b0, 2'd2},  // R4 two
    {12'd150, 1'b1, 1'b1, 1'b0, 2'd2},
    {12'd150, 1'b1, 1'b1, 1'b1, 2'd2},  // R5
    {12'd50,  1'b1, 1'b1, 1'b0, 2'd3},  // R4 three
    {12'd50,  1'b1, 1'b1, 1'b0, 2'd3},
    {12'd50,  1'b1, 1'b1, 1'b0, 2'd3},
    {12'd50,  1'b1, 1'b1, 1'b1, 2'd3},  // R5
    {12'd500, 1'b1, 1'b1, 1'b1, 2'd0},  // R3 hysteresis band
    {12'd650, 1'b1, 1'b0, 1'b1, 2'd0},  // R3 exit
    {12'd350, 1'b1, 1'b0, 1'b1, 2'd0},
    {12'd450, 1'b1, 1'b0, 1'b1, 2'd0},  // R2 streak broken
    {12'd350, 1'b1, 1'b0, 1'b1, 2'd0},
    {12'd350, 1'b1, 1'b0, 1'b1, 2'd0},
    {12'd350, 1'b1, 1'b0, 1'b1, 2'd0},
    {12'd350, 1'b1, 1'b1, 1'b1, 2'd0},  // R2 re-entry
    {12'd50,  1'b1, 1'b1, 1'b0, 2'd3}
  };

  task automatic chk(input int act, input int exp, input string tag);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // pulse zc, leave the caller two negedges after the decision edge
  task automatic zc_pulse(input logic [11:0] ld, input logic en);
    @(negedge clk_i);
    load_i = ld; burst_en_i = en; zc_i = 1'b1;
    @(negedge clk_i);
    zc_i = 1'b0;
    repeat (2) @(negedge clk_i);
  endtask

  task automatic cycle_chk(input logic [11:0] ld, input logic en, input int eb, input int ep,
                           input int es, input string tag);
    zc_pulse(ld, en);
    chk(burst_o, eb, {tag, " burst"});
    chk(pwm_en_o, ep, {tag, " pwm"});
    chk(skip_cnt_o, es, {tag, " skip"});
    repeat (6) @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(pwm_en_o, 1, "R9 pwm reset");
    chk(freeze_o, 0, "R9 freeze reset");
    chk(burst_o, 0, "R9 burst reset");
    chk(skip_cnt_o, 0, "R9 skip reset");
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    for (int i = 0; i < NV; i++)
      cycle_chk(VEC[i][16:5], VEC[i][4], int'(VEC[i][3]), int'(VEC[i][2]), int'(VEC[i][1:0]),
                $sformatf("R2/R3/R4/R5 vec%0d", i));

    // R6 emergency in the middle of a blanked cycle
    @(negedge clk_i); uv_i = 1'b1;
    @(negedge clk_i);
    chk(pwm_en_o, 1, "R6 pwm after uv");
    chk(burst_o, 0, "R6 burst after uv");
    uv_i = 1'b0;
    repeat (4) @(negedge clk_i);

    // R7 lockout of 3 crossings, then a full streak of 4
    for (int i = 0; i < 6; i++) cycle_chk(12'd50, 1'b1, 0, 1, 0, "R7 locked/streak");
    cycle_chk(12'd50, 1'b1, 1, 0, 3, "R7 entry after lockout");

    // R3 exit on disable, R2 no entry while disabled
    cycle_chk(12'd50, 1'b0, 0, 1, 0, "R3 disable exit");
    for (int i = 0; i < 5; i++) cycle_chk(12'd50, 1'b0, 0, 1, 0, "R2 disabled");

    // R8 freeze timing around an off edge and an on edge
    for (int i = 0; i < 4; i++) cycle_chk(12'd350, 1'b1, (i == 3) ? 1 : 0, 1, 0, "R8 setup");
    @(negedge clk_i); load_i = 12'd250; zc_i = 1'b1;
    @(negedge clk_i); zc_i = 1'b0;
    chk(freeze_o, 1, "R8 freeze leads");
    chk(pwm_en_o, 1, "R8 pwm still on");
    @(negedge clk_i);
    chk(freeze_o, 1, "R8 freeze held");
    chk(pwm_en_o, 0, "R8 pwm off");
    // R1 mid-cycle load change has no effect
    load_i = 12'd650;
    repeat (3) @(negedge clk_i);
    chk(pwm_en_o, 0, "R1 mid-cycle pwm");
    chk(burst_o, 1, "R1 mid-cycle burst");
    load_i = 12'd250;
    @(negedge clk_i); zc_i = 1'b1;
    @(negedge clk_i); zc_i = 1'b0;
    chk(pwm_en_o, 1, "R8 pwm on");
    chk(freeze_o, 1, "R8 freeze trails");
    @(negedge clk_i);
    chk(freeze_o, 0, "R8 freeze released");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule